// File: doc/BRIEF.md
# UART interrupt status and mask unit

This unit sits between the FIFO bookkeeping of a serial port and the interrupt controller. Every cycle it forms a live status word from the receive and transmit fill counts, compared against two programmable trigger levels. Selected live conditions and a set of one-cycle error strobes (receive overrun, framing, parity, receive timeout, transmit overflow) are caught in a sticky interrupt status register. Software clears that register by writing ones. A single interrupt line is raised whenever a sticky bit is also enabled in the mask.

The mask can only be changed through two write-only registers. One ORs bits into the mask and the other clears bits from it. A write aimed at the mask address itself does nothing. The FIFOs, baud generation and shift registers live elsewhere, so this unit only sees counts and strobes.

Register selects (3 bits): 0 mask-set, 1 mask-clear, 2 mask (read), 3 sticky status, 4 RX trigger level, 5 TX trigger level, 6 live status (read). Selects 0, 1 and 7 read as zero. Writes to 6 and 7 are dropped.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Live status (read at select 6) is recomputed every cycle. Bit 0 = RX count >= RX level, bit 1 = RX count is 0, bit 2 = RX count equals DEPTH, bit 3 = TX count is 0, bit 4 = TX count equals DEPTH. All other bits except bit 13 read 0.
- R2: TX count >= TX level shows at live bit 13. The same condition sets sticky bit 10.
- R3: On each clock edge, every live bit 0..4 that is high sets the sticky bit at the same position. A sticky bit stays set until it is cleared by a write.
- R4: A strobe sets a sticky bit on the next edge: RX overrun sets bit 5, framing sets bit 6, parity sets bit 7, timeout sets bit 8 and TX overflow sets bit 12. Sticky bits 9 and 11 are never set.
- R5: Writing select 3 clears every sticky bit where the written data holds a 1.
- R6: When a bit is set and cleared in the same cycle, it ends up set.
- R7: Writing select 0 ORs the data into the mask. Writing select 1 clears the mask bits where the data is 1. The mask reads back at select 2.
- R8: Writing select 2 leaves the mask unchanged.
- R9: The irq output is high exactly when mask AND sticky status is non-zero.
- R10: While reset is high, mask and sticky status are zero and both trigger levels are 32.
- R11: Writing select 4 or 5 loads the low CNT_W data bits as the RX or TX trigger level. The new level governs live bits 0 and 13 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 13 | Write data |
| rd_addr | input | 3 | Read register select |
| rd_data | output | 14 | Read data for rd_addr, combinational |
| rx_count | input | CNT_W | Receive FIFO fill count |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| ev_rx_ovr | input | 1 | Receive overrun strobe |
| ev_framing | input | 1 | Framing error strobe |
| ev_parity | input | 1 | Parity error strobe |
| ev_timeout | input | 1 | Receive timeout strobe |
| ev_tx_ovf | input | 1 | Transmit overflow strobe |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear that collides with a set: a write-one-to-clear of the sticky register landing in the same cycle as a live condition that keeps the bit asserted. The stimulus holds the FIFO counts at full and at threshold values while the all-ones clear is written, so the bench can see that the live bits survive. It then moves the counts out of those states and clears again, to confirm that a clear does take effect. A long randomized phase then mixes count changes, strobes and register traffic. Every clock, it compares the irq line and the selected read word against the behavioural model.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int LIVE_W   = 14;
    localparam int STICKY_W = 13;
    localparam int SEL_W    = 3;

    localparam int LB_RX_TRIG = 0;
    localparam int LB_RX_EMPT = 1;
    localparam int LB_RX_FULL = 2;
    localparam int LB_TX_EMPT = 3;
    localparam int LB_TX_FULL = 4;
    localparam int LB_TX_TRIG = 13;

    localparam int SB_RX_OVR  = 5;
    localparam int SB_FRAMING = 6;
    localparam int SB_PARITY  = 7;
    localparam int SB_TIMEOUT = 8;
    localparam int SB_TX_TRIG = 10;
    localparam int SB_TX_OVF  = 12;

    typedef enum logic [SEL_W-1:0] {
        SEL_MASK_SET = 3'd0,
        SEL_MASK_CLR = 3'd1,
        SEL_MASK     = 3'd2,
        SEL_STICKY   = 3'd3,
        SEL_RX_LVL   = 3'd4,
        SEL_TX_LVL   = 3'd5,
        SEL_LIVE     = 3'd6,
        SEL_NONE     = 3'd7
    } uirq_sel_e;

    typedef struct packed {
        logic tx_ovf;
        logic timeout;
        logic parity;
        logic framing;
        logic rx_ovr;
    } uirq_events_t;

    function automatic logic [STICKY_W-1:0] sticky_sources(
        input logic [LIVE_W-1:0] live,
        input uirq_events_t      ev
    );
        logic [STICKY_W-1:0] s;
        s             = '0;
        s[4:0]        = live[4:0];
        s[SB_TX_TRIG] = live[LB_TX_TRIG];
        s[SB_RX_OVR]  = ev.rx_ovr;
        s[SB_FRAMING] = ev.framing;
        s[SB_PARITY]  = ev.parity;
        s[SB_TIMEOUT] = ev.timeout;
        s[SB_TX_OVF]  = ev.tx_ovf;
        return s;
    endfunction

endpackage

// File: rtl/uirq_live_status.sv
module uirq_live_status
    import uirq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_lvl,
    input  logic [CNT_W-1:0]  tx_lvl,
    output logic [LIVE_W-1:0] live
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    always_comb begin
        live             = '0;
        live[LB_RX_TRIG] = (rx_count >= rx_lvl);
        live[LB_RX_EMPT] = (rx_count == '0);
        live[LB_RX_FULL] = (rx_count == FULL_CNT);
        live[LB_TX_EMPT] = (tx_count == '0);
        live[LB_TX_FULL] = (tx_count == FULL_CNT);
        live[LB_TX_TRIG] = (tx_count >= tx_lvl);
    end
endmodule

// File: rtl/uirq_level_reg.sv
module uirq_level_reg #(
    parameter int CNT_W     = 7,
    parameter int RESET_LVL = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] lvl_q
);
    always_ff @(posedge clk) begin
        if (rst)       lvl_q <= CNT_W'(RESET_LVL);
        else if (load) lvl_q <= value;
    end
endmodule

// File: rtl/uirq_setclr_reg.sv
module uirq_setclr_reg #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int RESET_LVL = 32,
    parameter int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_addr,
    input  logic [STICKY_W-1:0] wr_data,
    input  logic [SEL_W-1:0]    rd_addr,
    output logic [LIVE_W-1:0]   rd_data,
    input  logic [CNT_W-1:0]    rx_count,
    input  logic [CNT_W-1:0]    tx_count,
    input  logic                ev_rx_ovr,
    input  logic                ev_framing,
    input  logic                ev_parity,
    input  logic                ev_timeout,
    input  logic                ev_tx_ovf,
    output logic                irq
);
    localparam int N_LVL = 2;

    uirq_sel_e           wsel;
    uirq_sel_e           rsel;
    uirq_events_t        ev;
    logic [LIVE_W-1:0]   live_w;
    logic [STICKY_W-1:0] sticky_q;
    logic [STICKY_W-1:0] mask_q;
    logic [STICKY_W-1:0] sticky_set;
    logic [STICKY_W-1:0] sticky_clr;
    logic [STICKY_W-1:0] mask_set;
    logic [STICKY_W-1:0] mask_clr;
    logic [CNT_W-1:0]    lvl_q [N_LVL];

    assign wsel = uirq_sel_e'(wr_addr);
    assign rsel = uirq_sel_e'(rd_addr);
    assign ev   = '{tx_ovf: ev_tx_ovf, timeout: ev_timeout, parity: ev_parity,
                    framing: ev_framing, rx_ovr: ev_rx_ovr};

    // trigger levels: index 0 = RX, index 1 = TX
    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        localparam uirq_sel_e LVL_SEL = (g == 0) ? SEL_RX_LVL : SEL_TX_LVL;
        uirq_level_reg #(.CNT_W(CNT_W), .RESET_LVL(RESET_LVL)) i_lvl (
            .clk   (clk),
            .rst   (rst),
            .load  (wr_en && (wsel == LVL_SEL)),
            .value (wr_data[CNT_W-1:0]),
            .lvl_q (lvl_q[g])
        );
    end

    uirq_live_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_live (
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_lvl   (lvl_q[0]),
        .tx_lvl   (lvl_q[1]),
        .live     (live_w)
    );

    always_comb begin
        sticky_set = sticky_sources(live_w, ev);
        sticky_clr = (wr_en && wsel == SEL_STICKY)   ? wr_data : '0;
        mask_set   = (wr_en && wsel == SEL_MASK_SET) ? wr_data : '0;
        mask_clr   = (wr_en && wsel == SEL_MASK_CLR) ? wr_data : '0;
    end

    uirq_setclr_reg #(.W(STICKY_W)) i_sticky (
        .clk      (clk),
        .rst      (rst),
        .set_bits (sticky_set),
        .clr_bits (sticky_clr),
        .q        (sticky_q)
    );

    uirq_setclr_reg #(.W(STICKY_W)) i_mask (
        .clk      (clk),
        .rst      (rst),
        .set_bits (mask_set),
        .clr_bits (mask_clr),
        .q        (mask_q)
    );

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_MASK:   rd_data = LIVE_W'(mask_q);
            SEL_STICKY: rd_data = LIVE_W'(sticky_q);
            SEL_RX_LVL: rd_data = LIVE_W'(lvl_q[0]);
            SEL_TX_LVL: rd_data = LIVE_W'(lvl_q[1]);
            SEL_LIVE:   rd_data = live_w;
            default:    rd_data = '0;
        endcase
    end

    assign irq = |(mask_q & sticky_q);
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
    import uirq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [SEL_W-1:0]    wr_addr,
    input logic [STICKY_W-1:0] wr_data,
    input logic                ev_rx_ovr,
    input logic                ev_timeout,
    input logic [LIVE_W-1:0]   live,
    input logic [STICKY_W-1:0] sticky,
    input logic [STICKY_W-1:0] mask,
    input logic                irq
);
    logic                armed;
    logic [STICKY_W-1:0] clr_vec;
    logic [STICKY_W-1:0] live_src;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign clr_vec  = (wr_en && wr_addr == SEL_STICKY) ? wr_data : '0;
    assign live_src = {2'b00, live[LB_TX_TRIG], 5'b00000, live[4:0]};

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
        (($past(sticky) & ~$past(clr_vec) & ~sticky) == '0)); // R3
    AST_LIVE_SETS: assert property (@(posedge clk) disable iff (rst || !armed)
        ((sticky & $past(live_src)) == $past(live_src))); // R2
    AST_EVENT_OVR: assert property (@(posedge clk) disable iff (rst)
        ev_rx_ovr |=> sticky[SB_RX_OVR]); // R4
    AST_EVENT_TMO: assert property (@(posedge clk) disable iff (rst)
        ev_timeout |=> sticky[SB_TIMEOUT]); // R4
    AST_MASK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == SEL_MASK) |=> $stable(mask)); // R8
    AST_MASK_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == SEL_MASK_SET) |=> ((mask & $past(wr_data)) == $past(wr_data))); // R7
    AST_MASK_DISABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == SEL_MASK_CLR) |=> ((mask & $past(wr_data)) == '0)); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq); // R9
endmodule

bind uart_irq_ctrl uirq_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ev_rx_ovr  (ev_rx_ovr),
    .ev_timeout (ev_timeout),
    .live       (live_w),
    .sticky     (sticky_q),
    .mask       (mask_q),
    .irq        (irq)
);

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
    localparam int DEPTH = 64;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [12:0]      wr_data = '0;
    logic [2:0]       rd_addr = 3'd3;
    logic [13:0]      rd_data;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] tx_count = '0;
    logic ev_rx_ovr = 0, ev_framing = 0, ev_parity = 0, ev_timeout = 0, ev_tx_ovf = 0;
    logic irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int m_sticky, m_mask, m_rxlvl, m_txlvl;

    uart_irq_ctrl #(.DEPTH(DEPTH)) i_uart_irq_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_count(rx_count), .tx_count(tx_count),
        .ev_rx_ovr(ev_rx_ovr), .ev_framing(ev_framing), .ev_parity(ev_parity),
        .ev_timeout(ev_timeout), .ev_tx_ovf(ev_tx_ovf), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic int mlive();
        int v = 0;
        int rx = int'(rx_count);
        int tx = int'(tx_count);
        if (rx >= m_rxlvl) v |= 1;
        if (rx == 0)       v |= 2;
        if (rx == DEPTH)   v |= 4;
        if (tx == 0)       v |= 8;
        if (tx == DEPTH)   v |= 16;
        if (tx >= m_txlvl) v |= (1 << 13);
        return v;
    endfunction

    function automatic int mread(int sel);
        case (sel)
            2: return m_mask;
            3: return m_sticky;
            4: return m_rxlvl;
            5: return m_txlvl;
            6: return mlive();
            default: return 0;
        endcase
    endfunction

    function automatic string seltag(int sel);
        case (sel)
            2: return "R7";
            3: return "R5";
            4, 5: return "R11";
            6: return "R1";
            default: return "R1 (unused select)";
        endcase
    endfunction

    // reference model
    always @(posedge clk) begin
        int lv, setv, clr;
        if (rst) begin
            m_sticky = 0; m_mask = 0; m_rxlvl = 32; m_txlvl = 32;
        end else begin
            lv   = mlive();
            setv = (lv & 31) | (((lv >> 13) & 1) << 10);
            if (ev_rx_ovr)  setv |= 1 << 5;
            if (ev_framing) setv |= 1 << 6;
            if (ev_parity)  setv |= 1 << 7;
            if (ev_timeout) setv |= 1 << 8;
            if (ev_tx_ovf)  setv |= 1 << 12;
            clr = (wr_en && wr_addr == 3) ? int'(wr_data) : 0;
            m_sticky = ((m_sticky & ~clr) | setv) & 13'h1FFF;
            if (wr_en && wr_addr == 0) m_mask = m_mask | int'(wr_data);
            if (wr_en && wr_addr == 1) m_mask = m_mask & ~int'(wr_data);
            if (wr_en && wr_addr == 4) m_rxlvl = int'(wr_data) & ((1 << CNT_W) - 1);
            if (wr_en && wr_addr == 5) m_txlvl = int'(wr_data) & ((1 << CNT_W) - 1);
        end
    end

    task automatic expect_eq(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        expect_eq("R9 irq", int'(irq), ((m_mask & m_sticky) != 0) ? 1 : 0);
        expect_eq(seltag(int'(rd_addr)), int'(rd_data), mread(int'(rd_addr)));
    endtask

    task automatic peek(int sel, string tag, int exp);
        rd_addr = sel[2:0];
        #1;
        expect_eq(tag, int'(rd_data), exp);
    endtask

    task automatic wr(int sel, int data);
        wr_en = 1; wr_addr = sel[2:0]; wr_data = data[12:0];
        tick();
        wr_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        peek(2, "R10 mask", 0);
        peek(3, "R10 sticky", 0);
        peek(4, "R10 rx level", 32);
        peek(5, "R10 tx level", 32);
        expect_eq("R10 irq", int'(irq), 0);
        rst = 0;
        tick();
        peek(3, "R3 empty flags latched", 'h00A);
        peek(6, "R1 live empty", 'h00A);
        rx_count = 40; tx_count = 64;
        tick();
        peek(6, "R2 live tx trig at 13", 'h2011);
        peek(3, "R2 sticky tx trig at 10", 'h41B);
        rx_count = 64;
        tick();
        peek(6, "R1 live rx full", 'h2015);
        wr(3, 'h1FFF);
        peek(3, "R6 set wins over clear", 'h415);
        rx_count = 10; tx_count = 10;
        tick();
        peek(3, "R3 sticky holds", 'h415);
        wr(3, 'h1FFF);
        peek(3, "R5 w1c clears", 0);
        peek(6, "R1 live idle", 0);
        ev_rx_ovr = 1;  tick(); ev_rx_ovr = 0;
        ev_framing = 1; tick(); ev_framing = 0;
        ev_parity = 1;  tick(); ev_parity = 0;
        ev_timeout = 1; tick(); ev_timeout = 0;
        ev_tx_ovf = 1;  tick(); ev_tx_ovf = 0;
        peek(3, "R4 event bits", 'h11E0);
        wr(2, 'h1FFF);
        peek(2, "R8 direct mask write ignored", 0);
        expect_eq("R9 irq masked", int'(irq), 0);
        wr(0, 'h100);
        peek(2, "R7 enable", 'h100);
        expect_eq("R9 irq raised", int'(irq), 1);
        wr(0, 'h001);
        peek(2, "R7 enable ORs", 'h101);
        wr(1, 'h100);
        peek(2, "R7 disable", 'h001);
        expect_eq("R9 irq dropped", int'(irq), 0);
        wr(4, 4);
        rx_count = 3; tick();
        peek(6, "R11 below new rx level", 0);
        rx_count = 4; tick();
        peek(6, "R11 at new rx level", 'h1);
        wr(5, 10);
        peek(5, "R11 tx level", 10);
        peek(6, "R11 tx level governs bit 13", 'h2001);
        for (int i = 0; i < 2000; i++) begin
            int r = $urandom;
            rx_count   = CNT_W'($urandom % (DEPTH + 1));
            tx_count   = CNT_W'($urandom % (DEPTH + 1));
            if (r[3:2] == 0) rx_count = '0;
            if (r[5:4] == 0) tx_count = CNT_W'(DEPTH);
            ev_rx_ovr  = (r[9:8] == 0);
            ev_framing = (r[11:10] == 0);
            ev_parity  = (r[13:12] == 0);
            ev_timeout = (r[15:14] == 0);
            ev_tx_ovf  = (r[17:16] == 0);
            wr_en      = (r[19:18] != 0);
            wr_addr    = r[22:20];
            wr_data    = 13'($urandom);
            if (wr_addr == 4 || wr_addr == 5) wr_data = 13'($urandom % (DEPTH + 1));
            rd_addr    = r[26:24];
            tick();
        end
        wr_en = 0;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule